// File: doc/BRIEF.md
# Real-Time Clock Register File

This block is a clock/calendar register file that software reaches through two byte ports: an address port and a data port. A byte written to the address port picks one internal register. Later reads and writes on the data port go to that register. The block holds seven time fields: seconds, minutes, hours, weekday, day of month, month and year. It also holds four control/status registers. These return fixed or toggling values and ignore writes.

A free-running interval counter produces a single-cycle periodic interrupt every `TICK_CYCLES` system clock cycles. A 10-bit prescaler counts those interrupts. Each time it wraps, the seconds field advances modulo 60. Month and year are stored with an internal offset and translated at the data port. Month is stored zero-based. Year is stored as years since 1900 and presented with a bias of 52 removed.

Top module: `rtc_regfile`

## Requirements
- R1: `tick_irq` is high for exactly one cycle every `TICK_CYCLES` clock cycles. The interval counter reloads itself, so pulses continue without any software action.
- R2: A 10-bit prescaler counts `tick_irq` pulses. On the 1024th pulse it wraps, and the seconds field becomes (seconds + 1) mod 60, so 59 goes to 0.
- R3: A data-port read of index 8 (status A) returns 0x26 with bit 7 replaced by an update flag. The flag is 1 after reset and inverts after every read of index 8, and only after such a read.
- R4: A data-port read of index 9 returns 0x46. A read of index 10 returns 0x00.
- R5: Data-port writes to indices 8, 9, 10 and 11 are accepted and change nothing, including the status A update flag.
- R6: Month (index 5) is stored zero-based. A read returns the stored value plus 1, and a write stores the written value minus 1. After reset the stored value is 0, so a read returns 1.
- R7: Year (index 6) is stored as years since 1900. A read returns the stored value minus 52, and a write stores the written value plus 52, in 8-bit arithmetic. After reset the stored value is 100, so a read returns 48.
- R8: Seconds (0), minutes (1), hours (2), weekday (3) and day of month (4) are read and written as plain bytes. They reset to 0, and a write to one field leaves the others unchanged.
- R9: A data-port read of index 11, index 7 or any index from 12 to 255 returns 0xFF and raises `bus_rderr` for exactly the one cycle in which that data is presented. A write to such an index changes no field. Every other read leaves `bus_rderr` low.
- R10: A data-port write to the seconds field also clears the prescaler, so the next advance comes 1024 pulses after the write. If the write and a pulse meet in the same cycle, that pulse is not counted.
- R11: A write with `bus_dport`=0 selects the register index, which resets to 0. A read is answered on `bus_rdata` in the cycle after `bus_rd`, and `bus_rdata` holds its value while no read is issued. A read with `bus_dport`=0 returns 0x00 without an error, and `bus_rdata` is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_dport | input | 1 | Port select: 0 = address port, 1 = data port |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| bus_rderr | output | 1 | One-cycle flag for a read of an unsupported index |
| tick_irq | output | 1 | Single-cycle periodic interrupt pulse |

## Verification
The hardest state to reach from the ports is the seconds roll-over. It needs 1024 interrupt pulses counted exactly from a known prescaler phase. The bench writes the seconds field to zero the prescaler, then counts `tick_irq` pulses one by one on falling edges with a short interval. It reads the field one pulse before and one pulse after the wrap, once from 58 and once from 59. A seconds write placed in the middle of a count shows that the clear restarts the 1024-pulse window. A bench that ignored the clear would see the advance hundreds of pulses early.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;

  // Number of calendar fields held in the store (indices 0..FIELD_CNT-1)
  localparam int unsigned FIELD_CNT = 7;
  localparam int unsigned FIELD_IW  = 3;

  // Data-port register indices
  localparam logic [7:0] IDX_SEC   = 8'd0;
  localparam logic [7:0] IDX_MIN   = 8'd1;
  localparam logic [7:0] IDX_HOUR  = 8'd2;
  localparam logic [7:0] IDX_WDAY  = 8'd3;
  localparam logic [7:0] IDX_MDAY  = 8'd4;
  localparam logic [7:0] IDX_MON   = 8'd5;
  localparam logic [7:0] IDX_YEAR  = 8'd6;
  localparam logic [7:0] IDX_CTL_A = 8'd8;
  localparam logic [7:0] IDX_CTL_B = 8'd9;
  localparam logic [7:0] IDX_CTL_C = 8'd10;
  localparam logic [7:0] IDX_CTL_D = 8'd11;

  // Fixed read values
  localparam logic [6:0] CTL_A_LOW  = 7'h26;
  localparam logic [7:0] CTL_B_VAL  = 8'h46;
  localparam logic [7:0] CTL_C_VAL  = 8'h00;
  localparam logic [7:0] BAD_READ   = 8'hFF;
  localparam logic [7:0] ADDR_READ  = 8'h00;

  typedef enum logic [1:0] {
    XL_PLAIN,
    XL_MONTH,
    XL_YEAR,
    XL_NONE
  } xlate_e;

  function automatic xlate_e field_xlate(input int unsigned idx);
    if (idx == int'(IDX_MON))       return XL_MONTH;
    else if (idx == int'(IDX_YEAR)) return XL_YEAR;
    else if (idx < FIELD_CNT)       return XL_PLAIN;
    else                            return XL_NONE;
  endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int unsigned TICK_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);

  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= at_last;
      cnt_q  <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESC_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic clr_i,
  output logic step_o
);

  logic [PRESC_W-1:0] cnt_q;

  // Wrap of the count produces one seconds step; a clear swallows the tick
  assign step_o = tick_i && !clr_i && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_time_store.sv
module rtc_time_store
  import rtc_regfile_pkg::*;
#(
  parameter int unsigned MONTH_BIAS = 1,
  parameter int unsigned YEAR_BIAS  = 52,
  parameter int unsigned YEAR_RESET = 100,
  parameter int unsigned SEC_MOD    = 60
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_i,
  input  logic [FIELD_IW-1:0] wr_idx_i,
  input  logic [7:0]          wr_val_i,
  input  logic                sec_step_i,
  input  logic [FIELD_IW-1:0] rd_idx_i,
  output logic [7:0]          rd_val_o
);

  localparam int unsigned SLOTS = 2 ** FIELD_IW;

  logic [7:0] view [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_field
    localparam xlate_e XL = field_xlate(i);
    if (XL == XL_NONE) begin : g_empty
      assign view[i] = '0;
    end else begin : g_reg
      localparam logic [7:0] RST_VAL = (XL == XL_YEAR) ? 8'(YEAR_RESET) : 8'd0;
      logic [7:0] raw_q;
      logic [7:0] wr_conv;
      logic       hit;

      assign hit = wr_i && (wr_idx_i == FIELD_IW'(i));

      always_comb begin
        case (XL)
          XL_MONTH: wr_conv = wr_val_i - 8'(MONTH_BIAS);
          XL_YEAR:  wr_conv = wr_val_i + 8'(YEAR_BIAS);
          default:  wr_conv = wr_val_i;
        endcase
      end

      if (i == int'(IDX_SEC)) begin : g_sec
        logic [8:0] inc;
        assign inc = ({1'b0, raw_q} + 9'd1) % 9'(SEC_MOD);
        always_ff @(posedge clk) begin
          if (rst)             raw_q <= RST_VAL;
          else if (hit)        raw_q <= wr_conv;
          else if (sec_step_i) raw_q <= inc[7:0];
        end
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (rst)      raw_q <= RST_VAL;
          else if (hit) raw_q <= wr_conv;
        end
      end

      always_comb begin
        case (XL)
          XL_MONTH: view[i] = raw_q + 8'(MONTH_BIAS);
          XL_YEAR:  view[i] = raw_q - 8'(YEAR_BIAS);
          default:  view[i] = raw_q;
        endcase
      end
    end
  end

  assign rd_val_o = view[rd_idx_i];

endmodule

// File: rtl/rtc_ctl_status.sv
module rtc_ctl_status
  import rtc_regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_a_i,
  input  logic [1:0] sel_i,
  output logic [7:0] val_o,
  output logic       bad_o
);

  logic uip_q;

  always_ff @(posedge clk) begin
    if (rst)         uip_q <= 1'b1;
    else if (rd_a_i) uip_q <= ~uip_q;
  end

  always_comb begin
    bad_o = 1'b0;
    case (sel_i)
      2'd0:    val_o = {uip_q, CTL_A_LOW};
      2'd1:    val_o = CTL_B_VAL;
      2'd2:    val_o = CTL_C_VAL;
      default: begin
        val_o = BAD_READ;
        bad_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regfile_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 1000,
  parameter int unsigned PRESC_W     = 10,
  parameter int unsigned MONTH_BIAS  = 1,
  parameter int unsigned YEAR_BIAS   = 52,
  parameter int unsigned YEAR_RESET  = 100,
  parameter int unsigned SEC_MOD     = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_dport,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_rderr,
  output logic       tick_irq
);

  logic [7:0]          addr_q;
  logic                data_wr;
  logic                data_rd;
  logic                is_field;
  logic                is_ctl;
  logic [FIELD_IW-1:0] fidx;
  logic                sec_clr;
  logic                sec_step;
  logic [7:0]          store_val;
  logic [7:0]          ctl_val;
  logic                ctl_bad;
  logic [7:0]          rd_val;
  logic                rd_bad;

  assign data_wr  = bus_wr && bus_dport;
  assign data_rd  = bus_rd && bus_dport;
  assign is_field = (addr_q < 8'(FIELD_CNT));
  assign is_ctl   = (addr_q[7:2] == IDX_CTL_A[7:2]);
  assign fidx     = addr_q[FIELD_IW-1:0];
  assign sec_clr  = data_wr && (addr_q == IDX_SEC);

  always_ff @(posedge clk) begin
    if (rst)                      addr_q <= '0;
    else if (bus_wr && !bus_dport) addr_q <= bus_wdata;
  end

  rtc_tick_gen #(
    .TICK_CYCLES(TICK_CYCLES)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick_irq)
  );

  rtc_prescaler #(
    .PRESC_W(PRESC_W)
  ) u_presc (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_irq),
    .clr_i  (sec_clr),
    .step_o (sec_step)
  );

  rtc_time_store #(
    .MONTH_BIAS (MONTH_BIAS),
    .YEAR_BIAS  (YEAR_BIAS),
    .YEAR_RESET (YEAR_RESET),
    .SEC_MOD    (SEC_MOD)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (data_wr && is_field),
    .wr_idx_i   (fidx),
    .wr_val_i   (bus_wdata),
    .sec_step_i (sec_step),
    .rd_idx_i   (fidx),
    .rd_val_o   (store_val)
  );

  rtc_ctl_status u_ctl (
    .clk    (clk),
    .rst    (rst),
    .rd_a_i (data_rd && (addr_q == IDX_CTL_A)),
    .sel_i  (addr_q[1:0]),
    .val_o  (ctl_val),
    .bad_o  (ctl_bad)
  );

  always_comb begin
    if (is_field) begin
      rd_val = store_val;
      rd_bad = 1'b0;
    end else if (is_ctl) begin
      rd_val = ctl_val;
      rd_bad = ctl_bad;
    end else begin
      rd_val = BAD_READ;
      rd_bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_rderr <= 1'b0;
    end else begin
      bus_rderr <= data_rd && rd_bad;
      if (bus_rd) bus_rdata <= bus_dport ? rd_val : ADDR_READ;
    end
  end

endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
  parameter int unsigned TICK_CYCLES = 1000
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_rd,
  input logic       bus_dport,
  input logic [7:0] bus_rdata,
  input logic       bus_rderr,
  input logic       tick_irq
);

  logic [31:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)           gap_q <= '0;
    else if (tick_irq) gap_q <= 32'd1;
    else               gap_q <= gap_q + 32'd1;
  end

  assert_irq_period_R1: assert property (@(posedge clk) disable iff (rst)
    tick_irq |-> (gap_q == 32'(TICK_CYCLES)));

  assert_irq_no_miss_R1: assert property (@(posedge clk) disable iff (rst)
    gap_q <= 32'(TICK_CYCLES));

  assert_err_value_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rderr |-> (bus_rdata == 8'hFF));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rderr |-> $past(bus_rd && bus_dport));

  assert_addr_read_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_dport) |=> (bus_rdata == 8'h00 && !bus_rderr));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind rtc_regfile rtc_regfile_chk #(.TICK_CYCLES(TICK_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_dport (bus_dport),
  .bus_rdata (bus_rdata),
  .bus_rderr (bus_rderr),
  .tick_irq  (tick_irq)
);

// File: tb/rtc_regfile_bench.sv
`timescale 1ns/1ps
module rtc_regfile_bench;

  localparam int unsigned TB_TICK = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_dport = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rderr;
  logic       tick_irq;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  logic [7:0] rv;
  logic       re;

  always #4 clk = ~clk;

  rtc_regfile #(.TICK_CYCLES(TB_TICK)) u_rtc_regfile (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_dport (bus_dport),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rderr (bus_rderr),
    .tick_irq  (tick_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge
  task automatic sel(input logic [7:0] idx);
    bus_wr = 1'b1; bus_dport = 1'b0; bus_wdata = idx;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic put(input logic [7:0] v);
    bus_wr = 1'b1; bus_dport = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic get(input logic dport);
    bus_rd = 1'b1; bus_dport = dport;
    @(negedge clk);
    bus_rd = 1'b0;
    rv = bus_rdata;
    re = bus_rderr;
  endtask

  // Counts pulses visible on falling edges, starting at the current one
  task automatic wait_pulses(input int n);
    int c = 0;
    while (1) begin
      if (tick_irq) c++;
      if (c == n) break;
      @(negedge clk);
    end
  endtask

  // R1: pulse spacing monitor
  int  gap  = 0;
  bit  seen = 1'b0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      gap++;
      if (tick_irq) begin
        if (seen) chk("R1 irq interval", 8'(gap), 8'(TB_TICK));
        seen = 1'b1;
        gap  = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    chk("R11 rdata after reset", bus_rdata, 8'h00);
    chk("R9 rderr after reset", {7'd0, bus_rderr}, 8'h00);
    for (int i = 0; i < 5; i++) begin
      sel(8'(i)); get(1'b1);
      chk("R8 plain field reset", rv, 8'h00);
    end
    sel(8'd5); get(1'b1); chk("R6 month reset reads 1", rv, 8'd1);
    sel(8'd6); get(1'b1); chk("R7 year reset reads 48", rv, 8'd48);

    // Status A toggling flag
    sel(8'd8);
    get(1'b1); chk("R3 status A first", rv, 8'hA6);
    get(1'b1); chk("R3 status A second", rv, 8'h26);
    get(1'b1); chk("R3 status A third", rv, 8'hA6);
    put(8'hFF);
    get(1'b1); chk("R5 write A leaves flag", rv, 8'h26);
    sel(8'd9); get(1'b1); chk("R4 status B", rv, 8'h46);
    put(8'h00); get(1'b1); chk("R5 write B ignored", rv, 8'h46);
    sel(8'd10); get(1'b1); chk("R4 status C", rv, 8'h00);
    chk("R9 no error on C", {7'd0, re}, 8'h00);
    put(8'h55); get(1'b1); chk("R5 write C ignored", rv, 8'h00);
    sel(8'd11); put(8'h12);
    chk("R5 write D no error", {7'd0, bus_rderr}, 8'h00);

    // Unsupported reads
    get(1'b1);
    chk("R9 D reads FF", rv, 8'hFF);
    chk("R9 D read error", {7'd0, re}, 8'h01);
    @(negedge clk);
    chk("R9 error one cycle", {7'd0, bus_rderr}, 8'h00);
    sel(8'd7); get(1'b1);
    chk("R9 index 7 reads FF", rv, 8'hFF);
    chk("R9 index 7 error", {7'd0, re}, 8'h01);
    for (int i = 12; i < 256; i++) begin
      sel(8'(i)); get(1'b1);
      chk("R9 unknown reads FF", rv, 8'hFF);
      chk("R9 unknown error", {7'd0, re}, 8'h01);
    end
    sel(8'd8); get(1'b1); chk("R3 flag unaffected by other reads", rv, 8'hA6);

    // Address port read
    get(1'b0);
    chk("R11 address port read", rv, 8'h00);
    chk("R11 address port no error", {7'd0, re}, 8'h00);

    // Sweep all byte values through every field
    for (int f = 0; f < 7; f++) begin
      sel(8'(f));
      for (int v = 0; v < 256; v++) begin
        put(8'(v)); get(1'b1);
        if (f == 5)      chk("R6 month round trip", rv, 8'(v));
        else if (f == 6) chk("R7 year round trip", rv, 8'(v));
        else             chk("R8 plain round trip", rv, 8'(v));
      end
    end

    // Field isolation and ignored writes
    begin
      logic [7:0] vals [7];
      vals[0] = 8'd5;  vals[1] = 8'd17; vals[2] = 8'd23; vals[3] = 8'd6;
      vals[4] = 8'd31; vals[5] = 8'd12; vals[6] = 8'd125;
      for (int f = 0; f < 7; f++) begin sel(8'(f)); put(vals[f]); end
      sel(8'd200); put(8'h99);
      sel(8'd7);   put(8'h77);
      sel(8'd11);  put(8'h00);
      for (int f = 0; f < 7; f++) begin
        sel(8'(f)); get(1'b1);
        chk("R8 field isolated after writes", rv, vals[f]);
      end
    end

    // Seconds advance on the 1024th pulse
    sel(8'd0); put(8'd58);
    wait_pulses(1023);
    get(1'b1); chk("R2 no advance at 1023 pulses", rv, 8'd58);
    wait_pulses(1);
    @(negedge clk);
    get(1'b1); chk("R2 advance at 1024 pulses", rv, 8'd59);
    wait_pulses(1024);
    @(negedge clk);
    get(1'b1); chk("R2 seconds wrap 59 to 0", rv, 8'd0);

    // Seconds write clears the prescaler
    wait_pulses(600);
    put(8'd10);
    wait_pulses(1023);
    get(1'b1); chk("R10 clear restarts window", rv, 8'd10);
    wait_pulses(1);
    @(negedge clk);
    get(1'b1); chk("R10 advance after cleared window", rv, 8'd11);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule